// File: doc/BRIEF.md
# Stimulus Port Trace Unit

Software writes 32-bit words into any of a set of stimulus ports. The unit turns each accepted word into a trace record on a valid/ready output stream. A record carries the port number, a 7-bit source ID taken from the control register, and the data word. Configuration goes through a small word-addressed register interface. One write strobe, an address and write data update the registers, and a combinational read-data output returns the value at the current address.

A stimulus write reaches the stream only when four things allow it:

- the keyed write lock is open,
- the global enable is set,
- the port's own enable bit is set,
- the enable bit of its group of eight ports is set.

The output buffer holds one data record. While that buffer waits for the consumer, the unit reports busy and drops any further stimulus writes. When synchronisation is enabled, a timer adds a marked synchronisation record to the stream at a fixed interval. That record takes precedence over a data record that arrives in the same cycle.

Top module: `stim_trace_unit`

## Requirements
- R1: After reset the unit is locked, and the control, port-enable and group-mask registers read 0. No record is presented.
- R2: Word address 35 is the lock register, and it reads 1 while locked. Writing 0xC5ACCE55 there unlocks, and writing any other value locks. While locked, writes to addresses 32 (control), 33 (port enable) and 34 (group mask) are ignored.
- R3: Control (address 32) stores bits 4:0, 9:8 and 22:16. Bit 23 reads the busy flag. All other bits read 0.
- R4: A write at address n (0 to 31) is accepted only if all of these hold: the unit is unlocked, control bit 0 is set, enable bit n is set, mask bit n/8 is set, and the unit is not busy. An accepted write presents a record from the next cycle with sync=0, port=n, id=control bits 22:16 as they were at the write, and data=the written word.
- R5: Group-mask bit k (address 34, bits 3:0) gates ports 8k to 8k+7. With the bit clear, writes to those ports produce no record.
- R6: From an accepted write until its record's handshake, busy is 1 and further stimulus writes are dropped. The handshake is valid and ready high in the same cycle.
- R7: A read of address n (0 to 31) returns 1 in bit 0 exactly when a write to port n would be accepted in that cycle. All other bits read 0.
- R8: While valid is high and ready is low, the presented record and its type bit stay unchanged.
- R9: Synchronisation runs while control bits 0 and 2 are both set. A sync record is raised SYNC_PERIOD cycles after it is enabled, and again every SYNC_PERIOD cycles after that. The record has sync=1, port=0, data=0 and the source ID current at that moment. An interval that ends while an earlier sync record is still waiting is merged into it.
- R10: When a sync record and a data record become pending in the same cycle, the sync record is presented first and the data record follows.
- R11: Control bits 1, 3, 4 and 9:8 are read back but change no record or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| trace_valid_o | output | 1 | Record presented |
| trace_ready_i | input | 1 | Consumer accepts record |
| trace_sync_o | output | 1 | 1 for a sync record, 0 for data |
| trace_port_o | output | 5 | Stimulus port number |
| trace_id_o | output | 7 | Source ID |
| trace_data_o | output | 32 | Data word |

## Verification
An accepted stimulus write shows on the stream after the next clock edge. Busy and the port-status reads change at that same edge. Configuration and lock writes take effect at the edge that samples them. A sync record appears SYNC_PERIOD edges after the timer starts. The bench drives inputs and samples outputs one time unit after each falling edge, so every comparison sees state settled by the preceding rising edge. A behavioural model updated on that rising edge supplies the expected record, type bit and read data for every cycle. The same-cycle sync and data case is timed from the model's interval count.

// File: rtl/stim_trace_pkg.sv
package stim_trace_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;
  // config offsets above the stimulus window
  localparam int OFS_CTRL = 0;
  localparam int OFS_PEN  = 1;
  localparam int OFS_GRP  = 2;
  localparam int OFS_LOCK = 3;
  localparam int NUM_CFG  = 4;
  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_SYNC  = 2;
  localparam int CB_BUSY  = 23;
  localparam int CB_ID_LO = 16;
  localparam int ID_W     = 7;
  localparam logic [31:0] CTRL_WMASK = 32'h007F_031F;
endpackage

// File: rtl/stim_cfg_regs.sv
module stim_cfg_regs
  import stim_trace_pkg::*;
#(
  parameter int NUM_PORTS  = 32,
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic                  locked_o,
  output logic [31:0]           ctrl_o,
  output logic [NUM_PORTS-1:0]  port_en_o,
  output logic [NUM_GROUPS-1:0] grp_en_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_PORTS + OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_PEN  = ADDR_W'(NUM_PORTS + OFS_PEN);
  localparam logic [ADDR_W-1:0] A_GRP  = ADDR_W'(NUM_PORTS + OFS_GRP);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(NUM_PORTS + OFS_LOCK);

  logic                  locked_q;
  logic [31:0]           ctrl_q;
  logic [NUM_PORTS-1:0]  pen_q;
  logic [NUM_GROUPS-1:0] grp_q;
  logic                  cfg_we;

  assign cfg_we = we_i & ~locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      ctrl_q   <= '0;
      pen_q    <= '0;
      grp_q    <= '0;
    end else begin
      if (we_i && addr_i == A_LOCK) locked_q <= (wdata_i != UNLOCK_KEY);
      if (cfg_we && addr_i == A_CTRL) ctrl_q <= wdata_i & CTRL_WMASK;
      if (cfg_we && addr_i == A_PEN)  pen_q  <= wdata_i[NUM_PORTS-1:0];
      if (cfg_we && addr_i == A_GRP)  grp_q  <= wdata_i[NUM_GROUPS-1:0];
    end
  end

  assign locked_o  = locked_q;
  assign ctrl_o    = ctrl_q;
  assign port_en_o = pen_q;
  assign grp_en_o  = grp_q;
endmodule

// File: rtl/stim_gate.sv
module stim_gate #(
  parameter int NUM_PORTS  = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = NUM_PORTS / GROUP_SIZE
) (
  input  logic                  locked_i,
  input  logic                  glob_en_i,
  input  logic                  busy_i,
  input  logic [NUM_PORTS-1:0]  port_en_i,
  input  logic [NUM_GROUPS-1:0] grp_en_i,
  output logic [NUM_PORTS-1:0]  ok_o
);
  logic common_ok;
  assign common_ok = ~locked_i & glob_en_i & ~busy_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign ok_o[p] = common_ok & port_en_i[p] & grp_en_i[p / GROUP_SIZE];
  end
endmodule

// File: rtl/stim_sync_timer.sv
module stim_sync_timer #(
  parameter int SYNC_PERIOD = 1024,
  localparam int CNT_W = (SYNC_PERIOD > 2) ? $clog2(SYNC_PERIOD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_PERIOD - 1);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/stim_out_stage.sv
module stim_out_stage #(
  parameter int PORT_W = 5,
  parameter int ID_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PORT_W-1:0] push_port_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [31:0]       push_data_i,
  input  logic              sync_due_i,
  input  logic [ID_W-1:0]   sync_id_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              sync_o,
  output logic [PORT_W-1:0] port_o,
  output logic [ID_W-1:0]   id_o,
  output logic [31:0]       data_o,
  output logic              busy_o
);
  logic              dfull_q, sreq_q, lead_q;
  logic [PORT_W-1:0] dport_q;
  logic [ID_W-1:0]   did_q, sid_q;
  logic [31:0]       dword_q;
  logic              show_sync, fire, sync_set;

  // data keeps the lane once it has been shown and stalled
  assign show_sync = sreq_q & ~lead_q;
  assign valid_o   = dfull_q | sreq_q;
  assign fire      = valid_o & ready_i;
  assign sync_set  = sync_due_i & (~sreq_q | (fire & show_sync));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dfull_q <= 1'b0;
      sreq_q  <= 1'b0;
      lead_q  <= 1'b0;
      dport_q <= '0;
      did_q   <= '0;
      sid_q   <= '0;
      dword_q <= '0;
    end else begin
      lead_q <= valid_o & ~show_sync & ~ready_i;
      if (push_i) begin
        dfull_q <= 1'b1;
        dport_q <= push_port_i;
        did_q   <= push_id_i;
        dword_q <= push_data_i;
      end else if (fire && !show_sync) begin
        dfull_q <= 1'b0;
      end
      if (sync_set) begin
        sreq_q <= 1'b1;
        sid_q  <= sync_id_i;
      end else if (fire && show_sync) begin
        sreq_q <= 1'b0;
      end
    end
  end

  assign sync_o = show_sync;
  assign port_o = show_sync ? '0    : dport_q;
  assign id_o   = show_sync ? sid_q : did_q;
  assign data_o = show_sync ? '0    : dword_q;
  assign busy_o = dfull_q;
endmodule

// File: rtl/stim_trace_unit.sv
module stim_trace_unit
  import stim_trace_pkg::*;
#(
  parameter int NUM_PORTS   = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int SYNC_PERIOD = 1024,
  localparam int NUM_GROUPS = NUM_PORTS / GROUP_SIZE,
  localparam int PORT_W     = $clog2(NUM_PORTS),
  localparam int ADDR_W     = $clog2(NUM_PORTS + NUM_CFG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              trace_valid_o,
  input  logic              trace_ready_i,
  output logic              trace_sync_o,
  output logic [PORT_W-1:0] trace_port_o,
  output logic [ID_W-1:0]   trace_id_o,
  output logic [31:0]       trace_data_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_PORTS + OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_PEN  = ADDR_W'(NUM_PORTS + OFS_PEN);
  localparam logic [ADDR_W-1:0] A_GRP  = ADDR_W'(NUM_PORTS + OFS_GRP);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(NUM_PORTS + OFS_LOCK);

  logic                  locked_q;
  logic [31:0]           ctrl_q;
  logic [NUM_PORTS-1:0]  pen_q, port_ok;
  logic [NUM_GROUPS-1:0] grp_q;
  logic                  busy, sync_due, stim_hit, push;
  logic [PORT_W-1:0]     sel_port;
  logic [ID_W-1:0]       cur_id;

  assign stim_hit = reg_addr_i < ADDR_W'(NUM_PORTS);
  assign sel_port = reg_addr_i[PORT_W-1:0];
  assign cur_id   = ctrl_q[CB_ID_LO +: ID_W];

  stim_cfg_regs #(
    .NUM_PORTS(NUM_PORTS), .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .locked_o(locked_q), .ctrl_o(ctrl_q), .port_en_o(pen_q), .grp_en_o(grp_q)
  );

  stim_gate #(.NUM_PORTS(NUM_PORTS), .GROUP_SIZE(GROUP_SIZE)) u_gate (
    .locked_i(locked_q), .glob_en_i(ctrl_q[CB_EN]), .busy_i(busy),
    .port_en_i(pen_q), .grp_en_i(grp_q), .ok_o(port_ok)
  );

  assign push = reg_we_i & stim_hit & port_ok[sel_port];

  stim_sync_timer #(.SYNC_PERIOD(SYNC_PERIOD)) u_timer (
    .clk_i, .rst_ni,
    .run_i(ctrl_q[CB_EN] & ctrl_q[CB_SYNC]),
    .expire_o(sync_due)
  );

  stim_out_stage #(.PORT_W(PORT_W), .ID_W(ID_W)) u_out (
    .clk_i, .rst_ni,
    .push_i(push), .push_port_i(sel_port), .push_id_i(cur_id),
    .push_data_i(reg_wdata_i),
    .sync_due_i(sync_due), .sync_id_i(cur_id),
    .ready_i(trace_ready_i),
    .valid_o(trace_valid_o), .sync_o(trace_sync_o), .port_o(trace_port_o),
    .id_o(trace_id_o), .data_o(trace_data_o), .busy_o(busy)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (stim_hit) begin
      reg_rdata_o[0] = port_ok[sel_port];
    end else begin
      unique case (reg_addr_i)
        A_CTRL: begin
          reg_rdata_o          = ctrl_q;
          reg_rdata_o[CB_BUSY] = busy;
        end
        A_PEN:   reg_rdata_o[NUM_PORTS-1:0]  = pen_q;
        A_GRP:   reg_rdata_o[NUM_GROUPS-1:0] = grp_q;
        A_LOCK:  reg_rdata_o[0]              = locked_q;
        default: reg_rdata_o                 = '0;
      endcase
    end
  end
endmodule

// File: rtl/stim_trace_chk.sv
module stim_trace_chk
  import stim_trace_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int PORT_W    = 5,
  parameter int ADDR_W    = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              locked_i,
  input logic [31:0]       ctrl_i,
  input logic              valid_i,
  input logic              ready_i,
  input logic              sync_i,
  input logic [PORT_W-1:0] port_i,
  input logic [ID_W-1:0]   id_i,
  input logic [31:0]       data_i
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_PORTS + OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(NUM_PORTS + OFS_LOCK);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> valid_i && $stable(sync_i) && $stable(port_i)
                            && $stable(id_i) && $stable(data_i));

  p_key_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_LOCK && wdata_i == UNLOCK_KEY |=> !locked_i);

  p_bad_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_LOCK && wdata_i != UNLOCK_KEY |=> locked_i);

  p_cfg_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i && we_i && addr_i == A_CTRL |=> $stable(ctrl_i));

  p_locked_nodata_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i && we_i && addr_i < ADDR_W'(NUM_PORTS) && !valid_i
    |=> !(valid_i && !sync_i));

  p_sync_fields_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sync_i |-> port_i == '0 && data_i == '0);
endmodule

bind stim_trace_unit stim_trace_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
  .wdata_i(reg_wdata_i), .locked_i(locked_q), .ctrl_i(ctrl_q),
  .valid_i(trace_valid_o), .ready_i(trace_ready_i), .sync_i(trace_sync_o),
  .port_i(trace_port_o), .id_i(trace_id_o), .data_i(trace_data_o)
);

// File: tb/tb_stim_trace_unit.sv
`timescale 1ns/1ps
module tb_stim_trace_unit;
  localparam int P = 40;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;
  localparam logic [5:0] A_CTRL = 6'd32, A_PEN = 6'd33, A_GRP = 6'd34, A_LOCK = 6'd35;

  logic clk = 0, rst_n = 0;
  logic we = 0, ready = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic tv, ts;
  logic [4:0] tp;
  logic [6:0] tid;
  logic [31:0] td;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stim_trace_unit #(.SYNC_PERIOD(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .trace_valid_o(tv),
    .trace_ready_i(ready), .trace_sync_o(ts), .trace_port_o(tp),
    .trace_id_o(tid), .trace_data_o(td)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit m_locked, m_sreq, m_lead;
  logic [31:0] m_ctrl, m_en;
  logic [3:0] m_grp;
  logic [6:0] m_sid;
  int m_cnt;
  logic [43:0] m_q[$];
  logic [44:0] m_log[$];

  function automatic bit m_ok(int n);
    return !m_locked && m_ctrl[0] && m_en[n] && m_grp[n/8] && m_q.size() == 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_locked = 1; m_sreq = 0; m_lead = 0; m_ctrl = 0; m_en = 0;
      m_grp = 0; m_sid = 0; m_cnt = 0; m_q.delete();
    end else begin
      bit v, sh, fire, acc, run, exp_s, lead_n;
      v = m_q.size() > 0 || m_sreq;
      sh = m_sreq && !m_lead;
      fire = v && ready;
      acc = we && addr < 32 && m_ok(int'(addr));
      run = m_ctrl[0] && m_ctrl[2];
      exp_s = run && m_cnt == P-1;
      lead_n = v && !sh && !ready;
      if (fire) m_log.push_back(sh ? {1'b1, 5'd0, m_sid, 32'd0} : {1'b0, m_q[0]});
      if (fire && !sh) void'(m_q.pop_front());
      if (acc) m_q.push_back({addr[4:0], m_ctrl[22:16], wdata});
      if (exp_s && (!m_sreq || (fire && sh))) begin m_sreq = 1; m_sid = m_ctrl[22:16]; end
      else if (fire && sh) m_sreq = 0;
      m_cnt = !run ? 0 : (m_cnt == P-1 ? 0 : m_cnt + 1);
      m_lead = lead_n;
      if (we) begin
        if (addr == A_LOCK) m_locked = (wdata != KEY);
        else if (!m_locked) begin
          if (addr == A_CTRL) m_ctrl = wdata & 32'h007F_031F;
          if (addr == A_PEN) m_en = wdata;
          if (addr == A_GRP) m_grp = wdata[3:0];
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [31:0] er;
      bit ev, es;
      ev = m_q.size() > 0 || m_sreq;
      es = m_sreq && !m_lead;
      chk("R6 valid", tv, ev);
      if (ev) begin
        chk(es ? "R9 type" : "R10 type", ts, es);
        if (es) chk("R9 rec", {tp, tid, td}, {5'd0, m_sid, 32'd0});
        else chk("R4 rec", {tp, tid, td}, m_q[0]);
      end
      er = 0;
      if (addr < 32) er[0] = m_ok(int'(addr));
      else if (addr == A_CTRL) begin er = m_ctrl; er[23] = m_q.size() > 0; end
      else if (addr == A_PEN) er = m_en;
      else if (addr == A_GRP) er = {28'd0, m_grp};
      else if (addr == A_LOCK) er = {31'd0, m_locked};
      chk(addr < 32 ? "R7 rdata" : "R3 rdata", rdata, er);
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); we = 0; addr = a; #2 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      finish_up();
    end
  end

  initial begin
    logic [31:0] r;
    #20 rst_n = 1;
    // R1 reset state
    rd(A_LOCK, r); chk("R1 lock", r, 1);
    rd(A_CTRL, r); chk("R1 ctrl", r, 0);
    rd(A_PEN, r);  chk("R1 pen", r, 0);
    rd(A_GRP, r);  chk("R1 grp", r, 0);
    chk("R1 valid", tv, 0);
    // R2 locked writes ignored, wrong key, key
    wr(A_CTRL, 32'h0005_0001); rd(A_CTRL, r); chk("R2 locked ctrl", r, 0);
    wr(A_LOCK, 32'hC5AC_CE54); rd(A_LOCK, r); chk("R2 bad key", r, 1);
    wr(A_LOCK, KEY); rd(A_LOCK, r); chk("R2 unlock", r, 0);
    // R3 layout, R11 stored bits
    wr(A_CTRL, 32'hFFFF_FFFA); rd(A_CTRL, r); chk("R3 mask", r, 32'h007F_031A);
    wr(A_CTRL, 32'h0005_031B); rd(A_CTRL, r); chk("R11 ts bits", r, 32'h0005_031B);
    wr(A_PEN, 32'h0000_FF0F); wr(A_GRP, 32'h1);
    ready = 0;
    // R4 accepted write, record next cycle
    wr(6'd3, 32'hDEAD_0003);
    chk("R4 valid", tv, 1); chk("R4 port", tp, 3); chk("R4 id", tid, 5);
    chk("R4 data", td, 32'hDEAD_0003); chk("R4 type", ts, 0);
    rd(A_CTRL, r); chk("R6 busy", r[23], 1);
    rd(6'd2, r); chk("R7 busy blocks", r, 0);
    // R6 drop while busy
    wr(6'd2, 32'h1111_2222); chk("R6 drop", td, 32'hDEAD_0003);
    idle(3); chk("R8 hold", td, 32'hDEAD_0003);
    @(negedge clk); ready = 1; @(negedge clk); ready = 0;
    chk("R6 drained", tv, 0);
    rd(6'd2, r); chk("R7 ok", r, 1);
    rd(6'd5, r); chk("R7 port disabled", r, 0);
    // R5 group mask: port 8 enabled but group 1 masked
    wr(6'd8, 32'h0808_0808); chk("R5 masked", tv, 0);
    wr(A_GRP, 32'h3);
    wr(6'd9, 32'h0909_0909); chk("R5 open port", tp, 9);
    ready = 1; idle(2);
    // R4 global enable off
    wr(A_CTRL, 32'h0005_0000); wr(6'd1, 32'h5); chk("R4 glob off", tv, 0);
    // R9 sync
    m_log.delete();
    wr(A_CTRL, 32'h0007_0005);
    idle(P + 4);
    chk("R9 sync seen", m_log.size() > 0, 1);
    if (m_log.size() > 0) chk("R9 sync rec", m_log[0], {1'b1, 5'd0, 7'd7, 32'd0});
    // R10 same-cycle ordering
    m_log.delete();
    do @(negedge clk); while (m_cnt != P-1);
    we = 1; addr = 6'd0; wdata = 32'hABCD_0000;
    @(negedge clk); we = 0;
    chk("R10 sync first", ts, 1);
    idle(3);
    chk("R10 log n", m_log.size(), 2);
    if (m_log.size() == 2) begin
      chk("R10 first", m_log[0][44], 1);
      chk("R10 second", m_log[1], {1'b0, 5'd0, 7'd7, 32'hABCD_0000});
    end
    // random stress with mixed ready
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ready = ($urandom % 3) != 0;
      we = ($urandom % 2) == 0;
      addr = ($urandom % 8 == 0) ? 6'(32 + $urandom % 4) : 6'($urandom % 32);
      wdata = $urandom;
      if (addr == A_LOCK && ($urandom % 2 == 0)) wdata = KEY;
      if (addr == A_CTRL) wdata = wdata | 32'h1;
    end
    we = 0;
    // R2 relock then writes ignored
    wr(A_LOCK, 32'h0); rd(A_LOCK, r); chk("R2 relock", r, 1);
    wr(A_GRP, 32'h0); rd(A_GRP, r); chk("R2 grp frozen", r, {28'd0, m_grp});
    idle(5);
    finish_up();
  end
endmodule